// File: doc/BRIEF.md
# Read-Strobe Delay Pattern Tester

This block is the memory test engine behind a read-strobe delay calibration sweep. A caller gives it one candidate delay word, the size of the memory in words and a bias value, then pulses `start`. The block walks a series of test offsets through the memory. At each offset it loads a known-safe delay, fills a fixed-length region with a constant, overwrites that region with an address-derived pattern, switches the delay to the candidate and reads the region back. The first word that reads back wrong ends the run with a failure. A run that reads every word back correctly ends with a pass.

The caller runs the block once for each candidate in a sweep. A sweep that looks for the upper edge of the working window passes a bias of 3, and a sweep that looks for the lower edge passes a bias of 1. Memory traffic uses a single-outstanding request/response port. The delay setting leaves through a write strobe with a data word. After `done`, the delay is left at the candidate, and the caller restores it.

Top module: `rdly_pattern_tester`

## Requirements
- R1: After reset, `done`, `fail`, `req_valid` and `dly_we` are all low.
- R2: Test offsets are word addresses. They start at 0 and advance by `max(mem_words >> 6, 1)`. An offset is tested only while it is strictly below `mem_words - REGION`, where REGION = LINES * LINE_WORDS. When `mem_words <= REGION`, the run ends with a pass and makes no memory access.
- R3: Before any write at an offset, the delay is written with the safe word. Every 8-bit lane of that word is 0x74: coarse step 7 in bits [7:4] and fine step 4 in bits [3:0]. All writes take place under this word.
- R4: At each offset, every region word is first written with 0x1F1F1F1F in ascending index order. The region is then written again in ascending order with the 32-bit sum (offset + index + bias).
- R5: The candidate delay is written after the last pattern write and before the first read. Every read takes place under the candidate.
- R6: Reads go in ascending index order. The first word that differs from (offset + index + bias) ends the run with `fail` high, and no further request is issued.
- R7: `fail` stays low at `done` only if every word at every tested offset compared clean.
- R8: A request holds its address, direction and data until `req_ready`. At most one request is outstanding, and a read is complete only when `rsp_valid` arrives.
- R9: `done` is a single-cycle pulse. `fail` is valid with it and holds until the next accepted `start`. A `start` while a run is in progress is ignored.
- R10: After `done`, the delay is not rewritten, so it is left at the candidate whenever at least one offset was tested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; accepted only when idle |
| cand_dly | input | DLY_W | Candidate delay word under test |
| mem_words | input | AW+1 | Memory size in words |
| bias | input | BIAS_W | Value added into the expected pattern |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Run result, high on a mismatch |
| dly_we | output | 1 | Delay register write strobe |
| dly_wdata | output | DLY_W | Delay register write data |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | AW | Word address |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Read data valid |
| rsp_rdata | input | 32 | Read data |

## Verification
The bench targets the offset arithmetic at its edges:
- A size of exactly REGION, where a design using unsigned wrap would walk the whole address space.
- A size below 64, where a step of zero would hang the run.
- A limit of 1, where only offset 0 is legal.

It also targets candidates that sit exactly on either edge of the model's delay window, and one just past each edge. An inclusive/exclusive mix-up there would flip pass and fail. Single bad words placed at the last index of the last offset catch a design that stops one word or one offset early. Counting reads after a failure catches a design that keeps reading past the first mismatch. A start pulse during a long run must not change the candidate that the reads use.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  localparam int WORD_W = 32;
  localparam logic [7:0] SAFE_LANE = 8'h74;
  localparam logic [WORD_W-1:0] FILL_WORD = 32'h1F1F_1F1F;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FIRST, ST_SAFE, ST_FILL, ST_PAT,
    ST_CAND, ST_READ, ST_NEXT, ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {PT_IDLE, PT_REQ, PT_WAIT} port_state_t;

  // Expected word: region base + word index + bias, modulo 2^32
  function automatic logic [WORD_W-1:0] pattern_word(
      input logic [WORD_W-1:0] base,
      input logic [WORD_W-1:0] idx,
      input logic [WORD_W-1:0] bias);
    return base + idx + bias;
  endfunction

endpackage

// File: rtl/rpt_walker.sv
module rpt_walker #(
  parameter int AW     = 16,
  parameter int REGION = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [AW:0]       msize,
  input  logic              idx_inc,
  input  logic              idx_clr,
  input  logic              off_inc,
  output logic [AW-1:0]     base,
  output logic [$clog2(REGION)-1:0] idx,
  output logic              idx_last,
  output logic              first_ok,
  output logic              next_ok
);
  localparam int IW = $clog2(REGION);
  localparam logic [AW:0] REG_W = (AW+1)'(REGION);

  function automatic logic [AW:0] step_of(input logic [AW:0] m);
    logic [AW:0] s;
    s = m >> 6;
    if (s == '0) s = {{AW{1'b0}}, 1'b1};
    return s;
  endfunction

  function automatic logic [AW:0] limit_of(input logic [AW:0] m);
    return (m > REG_W) ? (m - REG_W) : '0;
  endfunction

  logic [AW:0]   off_q, step_q, limit_q;
  logic [IW-1:0] idx_q;
  logic [AW+1:0] nxt_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q   <= '0;
      step_q  <= '0;
      limit_q <= '0;
    end else if (restart) begin
      off_q   <= '0;
      step_q  <= step_of(msize);
      limit_q <= limit_of(msize);
    end else if (off_inc) begin
      off_q   <= off_q + step_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       idx_q <= '0;
    else if (idx_clr) idx_q <= '0;
    else if (idx_inc) idx_q <= idx_q + 1'b1;
  end

  assign nxt_off  = {1'b0, off_q} + {1'b0, step_q};
  assign next_ok  = nxt_off < {1'b0, limit_q};
  assign first_ok = limit_q != '0;
  assign base     = off_q[AW-1:0];
  assign idx      = idx_q;
  assign idx_last = idx_q == IW'(REGION - 1);

  // R2
  offset_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_inc |=> (off_q < limit_q));

endmodule

// File: rtl/rpt_mem_port.sv
module rpt_mem_port
  import rpt_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_write,
  input  logic [AW-1:0]     go_addr,
  input  logic [WORD_W-1:0] go_wdata,
  output logic              idle,
  output logic              wr_ack,
  output logic              rd_ack,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [AW-1:0]     req_addr,
  output logic [WORD_W-1:0] req_wdata,
  input  logic              rsp_valid
);
  port_state_t pst;
  logic        wr_q;
  logic [AW-1:0] addr_q;
  logic [WORD_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pst    <= PT_IDLE;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      unique case (pst)
        PT_IDLE: if (go) begin
          pst    <= PT_REQ;
          wr_q   <= go_write;
          addr_q <= go_addr;
          data_q <= go_wdata;
        end
        PT_REQ:  if (req_ready) pst <= wr_q ? PT_IDLE : PT_WAIT;
        PT_WAIT: if (rsp_valid) pst <= PT_IDLE;
        default: pst <= PT_IDLE;
      endcase
    end
  end

  assign idle      = pst == PT_IDLE;
  assign req_valid = pst == PT_REQ;
  assign req_write = wr_q;
  assign req_addr  = addr_q;
  assign req_wdata = data_q;
  assign wr_ack    = (pst == PT_REQ) && req_ready && wr_q;
  assign rd_ack    = (pst == PT_WAIT) && rsp_valid;

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                   && $stable(req_write) && $stable(req_wdata)));

  // R8
  go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> idle);

endmodule

// File: rtl/rdly_pattern_tester.sv
module rdly_pattern_tester
  import rpt_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DLY_W      = 16,
  parameter int BIAS_W     = 8,
  parameter int LINES      = 128,
  parameter int LINE_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DLY_W-1:0]  cand_dly,
  input  logic [AW:0]       mem_words,
  input  logic [BIAS_W-1:0] bias,
  output logic              done,
  output logic              fail,
  output logic              dly_we,
  output logic [DLY_W-1:0]  dly_wdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [AW-1:0]     req_addr,
  output logic [31:0]       req_wdata,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_rdata
);
  localparam int REGION = LINES * LINE_WORDS;
  localparam int IW     = $clog2(REGION);
  localparam int LANES  = DLY_W / 8;
  localparam logic [DLY_W-1:0] SAFE_DLY = {LANES{SAFE_LANE}};

  seq_state_t st;
  logic [DLY_W-1:0]  cand_q, dly_shadow;
  logic [BIAS_W-1:0] bias_q;
  logic              fail_q;

  logic              restart, idx_inc, idx_clr, off_inc;
  logic [AW-1:0]     base;
  logic [IW-1:0]     idx;
  logic              idx_last, first_ok, next_ok;

  logic              go, go_write, port_idle, wr_ack, rd_ack;
  logic [WORD_W-1:0] go_wdata, exp_word;
  logic [AW-1:0]     word_addr;
  logic              mismatch_evt;

  rpt_walker #(.AW(AW), .REGION(REGION)) u_walk (
    .clk(clk), .rst_n(rst_n), .restart(restart), .msize(mem_words),
    .idx_inc(idx_inc), .idx_clr(idx_clr), .off_inc(off_inc),
    .base(base), .idx(idx), .idx_last(idx_last),
    .first_ok(first_ok), .next_ok(next_ok));

  rpt_mem_port #(.AW(AW)) u_port (
    .clk(clk), .rst_n(rst_n), .go(go), .go_write(go_write),
    .go_addr(word_addr), .go_wdata(go_wdata), .idle(port_idle),
    .wr_ack(wr_ack), .rd_ack(rd_ack), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid));

  assign word_addr    = base + {{(AW-IW){1'b0}}, idx};
  assign exp_word     = pattern_word(WORD_W'(base), WORD_W'(idx), WORD_W'(bias_q));
  assign mismatch_evt = rd_ack && (rsp_rdata != exp_word);

  always_comb begin
    restart   = 1'b0;
    idx_inc   = 1'b0;
    idx_clr   = 1'b0;
    off_inc   = 1'b0;
    go        = 1'b0;
    go_write  = 1'b0;
    go_wdata  = FILL_WORD;
    dly_we    = 1'b0;
    dly_wdata = SAFE_DLY;
    unique case (st)
      ST_IDLE: restart = start;
      ST_SAFE: begin
        dly_we  = 1'b1;
        idx_clr = 1'b1;
      end
      ST_FILL, ST_PAT: begin
        go       = port_idle;
        go_write = 1'b1;
        go_wdata = (st == ST_FILL) ? FILL_WORD : exp_word;
        idx_inc  = wr_ack && !idx_last;
        idx_clr  = wr_ack && idx_last;
      end
      ST_CAND: begin
        dly_we    = 1'b1;
        dly_wdata = cand_q;
      end
      ST_READ: begin
        go      = port_idle;
        idx_inc = rd_ack && !idx_last && !mismatch_evt;
      end
      ST_NEXT: off_inc = next_ok;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cand_q <= '0;
      bias_q <= '0;
      fail_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          cand_q <= cand_dly;
          bias_q <= bias;
          fail_q <= 1'b0;
          st     <= ST_FIRST;
        end
        ST_FIRST: st <= first_ok ? ST_SAFE : ST_DONE;
        ST_SAFE:  st <= ST_FILL;
        ST_FILL:  if (wr_ack && idx_last) st <= ST_PAT;
        ST_PAT:   if (wr_ack && idx_last) st <= ST_CAND;
        ST_CAND:  st <= ST_READ;
        ST_READ:  if (mismatch_evt) begin
          fail_q <= 1'b1;
          st     <= ST_DONE;
        end else if (rd_ack && idx_last) begin
          st     <= ST_NEXT;
        end
        ST_NEXT:  st <= next_ok ? ST_SAFE : ST_DONE;
        ST_DONE:  st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  // Copy of the delay register as written, kept for the checks below
  always_ff @(posedge clk) begin
    if (!rst_n)      dly_shadow <= '0;
    else if (dly_we) dly_shadow <= dly_wdata;
  end

  assign done = st == ST_DONE;
  assign fail = fail_q;

  // R3
  write_under_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> (dly_shadow == SAFE_DLY));

  // R5
  read_under_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> (dly_shadow == cand_q));

  // R6
  fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> (done && $past(mismatch_evt)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st != ST_IDLE) |=> $stable(cand_q));

endmodule

// File: tb/sim_rdly_pattern_tester.sv
module sim_rdly_pattern_tester;
  localparam int AW = 8, DLY_W = 16, BIAS_W = 8, LINES = 4, LINE_WORDS = 2;
  localparam int REGION = LINES * LINE_WORDS;
  localparam logic [15:0] SAFE = 16'h7474;
  localparam logic [31:0] FILLV = 32'h1F1F1F1F;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [DLY_W-1:0] cand = '0;
  logic [AW:0] msize = '0;
  logic [BIAS_W-1:0] bias = '0;
  logic done, fail, dly_we, req_valid, req_write;
  logic [DLY_W-1:0] dly_wdata;
  logic [AW-1:0] req_addr;
  logic [31:0] req_wdata;
  logic req_ready = 0, rsp_valid = 0;
  logic [31:0] rsp_rdata = '0;

  always #10 clk = ~clk;

  rdly_pattern_tester #(.AW(AW), .DLY_W(DLY_W), .BIAS_W(BIAS_W),
    .LINES(LINES), .LINE_WORDS(LINE_WORDS)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cand_dly(cand),
    .mem_words(msize), .bias(bias), .done(done), .fail(fail),
    .dly_we(dly_we), .dly_wdata(dly_wdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [256];
  logic [15:0] dly_model = '0, cur_cand = '0;
  logic [7:0]  cur_bias = '0, win_lo = 0, win_hi = 8'hFF;
  int bad_addr = -1, step_g = 1;
  int exp_off = 0, exp_phase = 0, exp_idx = 0;
  int err_safe = 0, err_cand = 0, err_order = 0, err_hold = 0;
  int reads_seen = 0, writes_seen = 0;
  logic rd_pend = 0; int rd_cnt = 0; logic [31:0] rd_hold = '0;
  logic pv = 0, pr = 0, pw = 0; logic [AW-1:0] pa = '0; logic [31:0] pd = '0;

  function automatic bit in_win(logic [15:0] d);
    return d[7:0] >= win_lo && d[7:0] <= win_hi && d[15:8] >= win_lo && d[15:8] <= win_hi;
  endfunction
  function automatic int f_step(int m); return (m / 64 == 0) ? 1 : m / 64; endfunction
  function automatic int f_limit(int m); return (m > REGION) ? m - REGION : 0; endfunction
  function automatic int f_nofs(int m);
    int n = 0;
    for (int o = 0; o < f_limit(m); o += f_step(m)) n++;
    return n;
  endfunction

  // Behavioural memory: corrupts read data when the delay leaves the window
  always @(posedge clk) begin
    if (!rst_n) begin
      req_ready <= 0; rsp_valid <= 0; rd_pend <= 0; pv <= 0;
    end else begin
      rsp_valid <= 0;
      if (rd_pend) begin
        if (rd_cnt == 0) begin rsp_valid <= 1; rsp_rdata <= rd_hold; rd_pend <= 0; end
        else rd_cnt <= rd_cnt - 1;
      end
      if (dly_we) dly_model <= dly_wdata;
      if (pv && !pr && !(req_valid && req_addr == pa && req_write == pw && req_wdata == pd))
        err_hold++;
      if (req_valid && req_ready) begin
        if (req_write) begin
          writes_seen++;
          if (dly_model != SAFE) err_safe++;
          if (exp_phase > 1 || req_addr != AW'(exp_off + exp_idx) ||
              req_wdata != (exp_phase == 0 ? FILLV : 32'(exp_off + exp_idx) + 32'(cur_bias)))
            err_order++;
          mem[req_addr] <= req_wdata;
        end else begin
          reads_seen++;
          if (rd_pend) err_hold++;
          if (dly_model != cur_cand) err_cand++;
          if (exp_phase != 2 || req_addr != AW'(exp_off + exp_idx)) err_order++;
          rd_pend <= 1;
          rd_cnt  <= int'($urandom % 3);
          rd_hold <= (!in_win(dly_model) || int'(req_addr) == bad_addr)
                     ? mem[req_addr] ^ 32'h100 : mem[req_addr];
        end
        exp_idx++;
        if (exp_idx == REGION) begin
          exp_idx = 0; exp_phase++;
          if (exp_phase == 3) begin exp_phase = 0; exp_off += step_g; end
        end
      end
      pv <= req_valid; pr <= req_ready; pa <= req_addr; pw <= req_write; pd <= req_wdata;
      req_ready <= ($urandom % 4) != 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic run_case(input logic [15:0] c, input int m, input logic [7:0] b,
                          input logic [7:0] lo, input logic [7:0] hi, input int bad,
                          input bit poke);
    int nofs, e_fail, e_reads, e_writes, cyc, last_off, k, o;
    win_lo = lo; win_hi = hi;
    nofs = f_nofs(m); e_fail = 0; e_reads = nofs * REGION; e_writes = nofs * 2 * REGION;
    if (nofs > 0 && !in_win(c)) begin
      e_fail = 1; e_reads = 1; e_writes = 2 * REGION;
    end else if (nofs > 0 && bad >= 0) begin
      k = 0;
      for (o = 0; o < f_limit(m); o += f_step(m)) begin
        if (bad >= o && bad < o + REGION) begin
          e_fail = 1; e_reads = k * REGION + (bad - o) + 1; e_writes = (k + 1) * 2 * REGION;
          break;
        end
        k++;
      end
    end
    last_off = (nofs - 1) * f_step(m);
    cur_cand = c; cur_bias = b; bad_addr = bad; step_g = f_step(m);
    exp_off = 0; exp_phase = 0; exp_idx = 0;
    err_safe = 0; err_cand = 0; err_order = 0; err_hold = 0;
    reads_seen = 0; writes_seen = 0;
    @(negedge clk); start = 1; cand = c; msize = (AW+1)'(m); bias = b;
    @(negedge clk); start = 0;
    cyc = 0;
    while (!done && cyc < 60000) begin
      @(negedge clk); cyc++;
      if (poke && cyc == 20) begin start = 1; cand = ~c; bias = b + 8'd1; end
      else if (poke && cyc == 21) start = 0;
    end
    chk(done == 1, "R9 done reached", int'(done), 1);
    chk(fail == e_fail[0], "R6/R7 fail result", int'(fail), e_fail);
    chk(reads_seen == e_reads, "R2/R6 read count", reads_seen, e_reads);
    chk(writes_seen == e_writes, "R2/R4 write count", writes_seen, e_writes);
    chk(err_safe == 0, "R3 writes under safe delay", err_safe, 0);
    chk(err_cand == 0, "R5 reads under candidate", err_cand, 0);
    chk(err_order == 0, "R4 access order and data", err_order, 0);
    chk(err_hold == 0, "R8 request hold/outstanding", err_hold, 0);
    if (nofs > 0 && e_fail == 0)
      chk(mem[last_off + REGION - 1] == 32'(last_off + REGION - 1) + 32'(b),
          "R4 final pattern word", int'(mem[last_off + REGION - 1]),
          last_off + REGION - 1 + int'(b));
    @(negedge clk);
    chk(done == 0, "R9 done single pulse", int'(done), 0);
    chk(fail == e_fail[0], "R9 fail held", int'(fail), e_fail);
    repeat (3) @(negedge clk);
    if (nofs > 0)
      chk(dly_model == c, "R10 delay left at candidate", int'(dly_model), int'(c));
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd17));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(done == 0 && fail == 0 && req_valid == 0 && dly_we == 0,
        "R1 reset outputs", int'({done, fail, req_valid, dly_we}), 0);
    // Directed edges of the offset arithmetic (R2)
    run_case(16'h5050, 0,   8'd3, 8'h40, 8'h60, -1, 0);
    run_case(16'h5050, 8,   8'd3, 8'h40, 8'h60, -1, 0);
    run_case(16'h5050, 9,   8'd1, 8'h40, 8'h60, -1, 0);
    run_case(16'h5050, 63,  8'd3, 8'h40, 8'h60, -1, 0);
    run_case(16'h5050, 256, 8'd1, 8'h40, 8'h60, -1, 1);
    // Window edges (R6/R7)
    run_case(16'h4040, 100, 8'd3, 8'h40, 8'h60, -1, 0);
    run_case(16'h6060, 100, 8'd1, 8'h40, 8'h60, -1, 0);
    run_case(16'h6160, 100, 8'd3, 8'h40, 8'h60, -1, 0);
    run_case(16'h403F, 100, 8'd1, 8'h40, 8'h60, -1, 0);
    // Single bad word: last index of the last offset, then mid-region
    run_case(16'h5050, 100, 8'd3, 8'h40, 8'h60, f_limit(100) - 1 + REGION - 1, 0);
    run_case(16'h5050, 200, 8'd1, 8'h40, 8'h60, 37, 0);
    // Constrained random
    for (int i = 0; i < 14; i++) begin
      logic [7:0] lo, hi, l0, l1;
      int m, bad;
      lo = 8'($urandom_range(0, 112)); hi = lo + 8'($urandom_range(0, 96));
      if ($urandom % 3 != 0) begin
        l0 = lo + 8'($urandom_range(0, int'(hi - lo)));
        l1 = lo + 8'($urandom_range(0, int'(hi - lo)));
      end else begin
        l0 = hi + 8'd1; l1 = lo;
      end
      m = $urandom_range(0, 256);
      bad = ($urandom % 4 == 0) ? $urandom_range(0, 255) : -1;
      run_case({l1, l0}, m, ($urandom % 2) ? 8'd3 : 8'd1, lo, hi, bad, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule